// File: doc/BRIEF.md
# Pulse-Width Clock-Command Codec

This block sends a free-running, clock-like pulse train over a single AC-coupled line and carries 4-bit commands in it by varying pulse widths. The rising edges keep a fixed spacing whatever the data, so the far end can use the line as a clock. A transmitter and a receiver are packaged together. Each has its own clock and reset, so the receiver can run from an independent oscillator that oversamples the line.

The transmitter accepts a nibble through a valid/ready handshake. It emits a frame of five pulses, each four transmit cycles long. The first pulse is always wide, and the four pulses after it encode the nibble, with the high time of the whole frame held to that of five normal pulses. While no command is pending it emits normal pulses only.

The receiver synchronises the line and measures the high time of each pulse. While hunting it treats a wide pulse as the start of a frame and classifies the four pulses that follow. It then issues a single-cycle data strobe, or a single-cycle error strobe when the pattern is not a legal code.

Top module: `pwcc_codec`

## Requirements
- R1: While reset is held, tx_ready is 1, tx_line is 0, rx_valid is 0 and rx_err is 0.
- R2: tx_line has a rising edge exactly every 4 tx_clk cycles, in idle, inside frames and across frame boundaries.
- R3: With no command pending, every pulse is high for 2 cycles (normal width), and the receiver raises neither rx_valid nor rx_err for such pulses.
- R4: A frame begins on the cycle after acceptance. Its first pulse is high for 3 cycles and low for 1, and the 20 cycles of the frame contain exactly 10 high cycles.
- R5: Code table: pulse k (k = 2..5) has trit t_k = high cycles - 1, in 0..2. The nibble n is sent as the n-th (counting from 0) smallest value of V = 27*t2 + 9*t3 + 3*t4 + t5 among the patterns whose trits sum to 3.
- R6: tx_ready is 1 only in the last cycle of a 4-cycle idle pulse or of a frame. A nibble is taken at a tx_clk edge where tx_valid and tx_ready are both 1. Changes to tx_data after that edge do not affect the frame being sent.
- R7: The receiver pulses rx_valid for one cycle with rx_data equal to the sent nibble, SYNC_STAGES + 17 + w5 rx_clk cycles after the acceptance edge, where w5 is the high time of the fifth pulse.
- R8: With h counted in rx_clk cycles and S = OVERSAMPLE, the receiver classes a pulse as narrow when 2h < 3S, normal when 2h < 5S, wide when 2h < 7S, and invalid otherwise. While hunting, only a wide pulse starts a frame; narrow and normal pulses are ignored.
- R9: When the four pulses after a start pulse do not form a code of R5, the receiver pulses rx_err for one cycle, does not raise rx_valid, and goes back to hunting.
- R10: rx_valid and rx_err are never 1 together, and each lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock |
| tx_rst_n | input | 1 | Transmit reset, active low |
| tx_valid | input | 1 | Command nibble offered |
| tx_ready | output | 1 | Transmitter at a frame boundary, can take a nibble |
| tx_data | input | 4 | Command nibble |
| tx_line | output | 1 | Pulse-train line output |
| rx_clk | input | 1 | Receive clock, free running |
| rx_rst_n | input | 1 | Receive reset, active low |
| rx_line | input | 1 | Pulse-train line input |
| rx_valid | output | 1 | One-cycle strobe, decoded nibble valid |
| rx_data | output | 4 | Decoded nibble |
| rx_err | output | 1 | One-cycle strobe, malformed frame |

## Verification
The frame starts on the cycle after the acceptance edge, and its first-pulse shape, high-time total and ready profile are checked over cycles 0 to 19 counted from there. The receive strobe is due SYNC_STAGES + 17 + w5 cycles after acceptance, which is 19 + w5 with two synchroniser stages. Here w5 comes from the bench's own enumeration of the code table. The driver stores that due cycle with each expected nibble, and the monitor compares it with the cycle counter when the strobe appears. Injected frames have no acceptance edge, so they are checked on data and error counts within a fixed window of idle pulses that follows them.

// File: rtl/pwcc_pkg.sv
package pwcc_pkg;
  localparam int FRAME_PULSES = 5;
  localparam int PULSE_CYCLES = 4;
  localparam int PAT_W        = 2 * (FRAME_PULSES - 1);
  localparam int TRIT_SPACE   = 81;

  typedef enum logic [1:0] {
    W_NARROW = 2'd0,
    W_NORMAL = 2'd1,
    W_WIDE   = 2'd2,
    W_BAD    = 2'd3
  } width_e;

  function automatic int trit_sum(input int v);
    return (v / 27) + ((v / 9) % 3) + ((v / 3) % 3) + (v % 3);
  endfunction

  // nibble -> four trits, pulse 2 in the top pair
  function automatic logic [PAT_W-1:0] pwcc_encode(input logic [3:0] nib);
    logic [PAT_W-1:0] pat;
    int rank;
    pat  = '0;
    rank = 0;
    for (int v = 0; v < TRIT_SPACE; v++) begin
      if (trit_sum(v) == 3) begin
        if (rank == int'(nib))
          pat = {2'(v / 27), 2'((v / 9) % 3), 2'((v / 3) % 3), 2'(v % 3)};
        rank++;
      end
    end
    return pat;
  endfunction

  // four trits -> {legal, nibble}
  function automatic logic [4:0] pwcc_decode(input logic [PAT_W-1:0] pat);
    int a, b, c, d, v, rank;
    a = int'(pat[7:6]);
    b = int'(pat[5:4]);
    c = int'(pat[3:2]);
    d = int'(pat[1:0]);
    if (a == 3 || b == 3 || c == 3 || d == 3 || (a + b + c + d) != 3)
      return 5'd0;
    v    = 27 * a + 9 * b + 3 * c + d;
    rank = 0;
    for (int w = 0; w < TRIT_SPACE; w++)
      if (w < v && trit_sum(w) == 3) rank++;
    return {1'b1, 4'(rank)};
  endfunction

  // high time in receive cycles -> width class
  function automatic width_e pwcc_classify(input int h, input int os);
    if (2 * h < 3 * os)      return W_NARROW;
    else if (2 * h < 5 * os) return W_NORMAL;
    else if (2 * h < 7 * os) return W_WIDE;
    else                     return W_BAD;
  endfunction
endpackage

// File: rtl/pwcc_tx.sv
module pwcc_tx
  import pwcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [3:0] in_data,
  output logic       line,
  output logic       frame_start
);
  localparam logic [2:0] LAST_SLOT = 3'(FRAME_PULSES - 1);
  localparam logic [1:0] LAST_PH   = 2'(PULSE_CYCLES - 1);

  logic [1:0]       ph;
  logic [2:0]       slot;
  logic             active;
  logic [PAT_W-1:0] pat;
  logic [1:0]       trit;
  logic [1:0]       width;

  assign in_ready    = (ph == LAST_PH) && (!active || slot == LAST_SLOT);
  assign frame_start = in_valid && in_ready;

  always_comb begin
    case (slot)
      3'd1:    trit = pat[7:6];
      3'd2:    trit = pat[5:4];
      3'd3:    trit = pat[3:2];
      default: trit = pat[1:0];
    endcase
    if (!active)        width = 2'd2;
    else if (slot == 0) width = 2'd3;
    else                width = trit + 2'd1;
  end

  assign line = (ph < width);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= LAST_PH;
      slot   <= '0;
      active <= 1'b0;
      pat    <= '0;
    end else begin
      ph <= ph + 2'd1;
      if (ph == LAST_PH) begin
        if (frame_start) begin
          active <= 1'b1;
          slot   <= '0;
          pat    <= pwcc_encode(in_data);
        end else if (active && slot != LAST_SLOT) begin
          slot <= slot + 3'd1;
        end else begin
          active <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/pwcc_sync.sv
module pwcc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pwcc_rx.sv
module pwcc_rx
  import pwcc_pkg::*;
#(
  parameter int OVERSAMPLE = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       line_s,
  output logic       out_valid,
  output logic [3:0] out_data,
  output logic       out_err,
  output logic       fall
);
  localparam int             CNT_W = $clog2(PULSE_CYCLES * OVERSAMPLE + 1) + 2;
  localparam logic [CNT_W-1:0] HMAX = '1;

  logic             s_d;
  logic [CNT_W-1:0] hcnt;
  logic             hunting;
  logic [1:0]       idx;
  logic [5:0]       sh;
  logic             rise;
  width_e           cls;
  logic [1:0]       cls_bits;
  logic [PAT_W-1:0] full;
  logic [4:0]       dec;

  assign rise     = line_s & ~s_d;
  assign fall     = ~line_s & s_d;
  assign cls      = pwcc_classify(int'(hcnt), OVERSAMPLE);
  assign cls_bits = cls;
  assign full     = {sh, cls_bits};
  assign dec      = pwcc_decode(full);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s_d       <= 1'b0;
      hcnt      <= '0;
      hunting   <= 1'b1;
      idx       <= '0;
      sh        <= '0;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      out_data  <= '0;
    end else begin
      s_d       <= line_s;
      out_valid <= 1'b0;
      out_err   <= 1'b0;
      if (rise)                        hcnt <= CNT_W'(1);
      else if (line_s && hcnt != HMAX) hcnt <= hcnt + 1'b1;
      if (fall) begin
        if (hunting) begin
          if (cls == W_WIDE) begin
            hunting <= 1'b0;
            idx     <= '0;
          end
        end else begin
          sh  <= {sh[3:0], cls_bits};
          idx <= idx + 2'd1;
          if (idx == 2'd3) begin
            hunting <= 1'b1;
            if (dec[4]) begin
              out_valid <= 1'b1;
              out_data  <= dec[3:0];
            end else begin
              out_err <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwcc_codec.sv
module pwcc_codec
  import pwcc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int OVERSAMPLE  = 1
) (
  input  logic       tx_clk,
  input  logic       tx_rst_n,
  input  logic       tx_valid,
  output logic       tx_ready,
  input  logic [3:0] tx_data,
  output logic       tx_line,
  input  logic       rx_clk,
  input  logic       rx_rst_n,
  input  logic       rx_line,
  output logic       rx_valid,
  output logic [3:0] rx_data,
  output logic       rx_err
);
  logic tx_accept;
  logic rx_line_s;
  logic rx_fall;

  pwcc_tx u_tx (
    .clk         (tx_clk),
    .rst_n       (tx_rst_n),
    .in_valid    (tx_valid),
    .in_ready    (tx_ready),
    .in_data     (tx_data),
    .line        (tx_line),
    .frame_start (tx_accept)
  );

  pwcc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (rx_clk),
    .rst_n (rx_rst_n),
    .d     (rx_line),
    .q     (rx_line_s)
  );

  pwcc_rx #(.OVERSAMPLE(OVERSAMPLE)) u_rx (
    .clk       (rx_clk),
    .rst_n     (rx_rst_n),
    .line_s    (rx_line_s),
    .out_valid (rx_valid),
    .out_data  (rx_data),
    .out_err   (rx_err),
    .fall      (rx_fall)
  );
endmodule

// File: rtl/pwcc_codec_chk.sv
module pwcc_codec_chk (
  input logic tx_clk,
  input logic tx_rst_n,
  input logic tx_valid,
  input logic tx_ready,
  input logic tx_line,
  input logic tx_accept,
  input logic rx_clk,
  input logic rx_rst_n,
  input logic rx_valid,
  input logic rx_err,
  input logic rx_fall
);
  logic       prev_line;
  logic [2:0] since_rise;
  logic       seen_rise;
  logic       line_rise;

  assign line_rise = tx_line & ~prev_line;

  always_ff @(posedge tx_clk or negedge tx_rst_n) begin
    if (!tx_rst_n) begin
      prev_line  <= 1'b0;
      since_rise <= '0;
      seen_rise  <= 1'b0;
    end else begin
      prev_line <= tx_line;
      if (line_rise) begin
        since_rise <= 3'd1;
        seen_rise  <= 1'b1;
      end else if (since_rise != 3'd7) begin
        since_rise <= since_rise + 3'd1;
      end
    end
  end

  AST_RISE_PERIOD: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (line_rise && seen_rise) |-> since_rise == 3'd4); // R2
  AST_FIRST_WIDE: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_accept |=> tx_line ##1 tx_line ##1 tx_line ##1 !tx_line); // R4
  AST_READY_DROPS: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    (tx_valid && tx_ready) |=> !tx_ready); // R6
  AST_READY_LINE_LOW: assert property (@(posedge tx_clk) disable iff (!tx_rst_n)
    tx_ready |-> !tx_line); // R6
  AST_VALID_AFTER_FALL: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_valid |-> $past(rx_fall)); // R7
  AST_STROBE_EXCL: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !(rx_valid && rx_err)); // R10
  AST_VALID_PULSE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_valid |=> !rx_valid); // R10
  AST_ERR_PULSE: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    rx_err |=> !rx_err); // R9
endmodule

bind pwcc_codec pwcc_codec_chk u_chk (
  .tx_clk    (tx_clk),
  .tx_rst_n  (tx_rst_n),
  .tx_valid  (tx_valid),
  .tx_ready  (tx_ready),
  .tx_line   (tx_line),
  .tx_accept (tx_accept),
  .rx_clk    (rx_clk),
  .rx_rst_n  (rx_rst_n),
  .rx_valid  (rx_valid),
  .rx_err    (rx_err),
  .rx_fall   (rx_fall)
);

// File: tb/pwcc_codec_tb.sv
module pwcc_codec_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tx_valid;
  logic [3:0] tx_data;
  logic       tx_ready;
  logic       tx_line;
  logic       inj_en;
  logic       inj_line;
  logic       rx_line;
  logic       rx_valid;
  logic [3:0] rx_data;
  logic       rx_err;

  always #2 clk = ~clk;

  assign rx_line = inj_en ? inj_line : tx_line;

  pwcc_codec u_dut (
    .tx_clk   (clk),
    .tx_rst_n (rst_n),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready),
    .tx_data  (tx_data),
    .tx_line  (tx_line),
    .rx_clk   (clk),
    .rx_rst_n (rst_n),
    .rx_line  (rx_line),
    .rx_valid (rx_valid),
    .rx_data  (rx_data),
    .rx_err   (rx_err)
  );

  int n_chk = 0;
  int n_err = 0;
  int cyc   = 0;
  int err_cnt = 0;
  int tbl_hi [16][4];
  int q_data [$];
  int q_due  [$];
  int q_fs   [$];

  always @(posedge clk) cyc = cyc + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // R5 table, built as nested trit loops in ascending V order
  initial begin
    int k;
    k = 0;
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++)
        for (int c = 0; c < 3; c++)
          for (int d = 0; d < 3; d++)
            if (a + b + c + d == 3) begin
              tbl_hi[k][0] = a + 1;
              tbl_hi[k][1] = b + 1;
              tbl_hi[k][2] = c + 1;
              tbl_hi[k][3] = d + 1;
              k++;
            end
  end

  task automatic send(input int nib);
    int e0;
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = 4'(nib);
    while (!tx_ready) @(negedge clk);
    e0 = cyc + 1;
    q_data.push_back(nib);
    q_due.push_back(e0 + 19 + tbl_hi[nib][3]);
    q_fs.push_back(e0);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data  = ~4'(nib); // R6: must not alter the frame
  endtask

  task automatic inj_pulse(input int hi, input int period);
    for (int i = 0; i < period; i++) begin
      inj_line = (i < hi);
      @(negedge clk);
    end
    inj_line = 1'b0;
  endtask

  // monitor: strobes, rise spacing, frame window
  logic prev_line = 1'b0;
  logic prev_valid = 1'b0;
  int   last_rise = -1;
  int   fs = -1;
  int   hsum, first_bad, rdy_bad;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid && rx_err) chk(1'b0, "R10 both strobes", 1, 0);
      if (rx_valid && prev_valid) chk(1'b0, "R10 valid length", 2, 1);
      if (rx_valid) begin
        if (q_data.size() == 0) begin
          chk(1'b0, "R3/R8 unexpected rx_valid", int'(rx_data), -1);
        end else begin
          int ed, du;
          ed = q_data.pop_front();
          du = q_due.pop_front();
          chk(int'(rx_data) == ed, "R5/R7 rx_data", int'(rx_data), ed);
          if (du >= 0) chk(cyc == du, "R7 strobe cycle", cyc, du);
        end
      end
      if (rx_err) err_cnt++;
      if (tx_line && !prev_line) begin
        if (last_rise >= 0) chk(cyc - last_rise == 4, "R2 rise spacing", cyc - last_rise, 4);
        last_rise = cyc;
      end
      if (q_fs.size() > 0 && q_fs[0] == cyc) begin
        fs = q_fs.pop_front();
        hsum = 0;
        first_bad = 0;
        rdy_bad = 0;
      end
      if (fs >= 0) begin
        int off;
        off = cyc - fs;
        hsum += int'(tx_line);
        if (off < 4 && tx_line != (off < 3)) first_bad++;
        if (tx_ready != (off == 19)) rdy_bad++;
        if (off == 19) begin
          chk(hsum == 10, "R4 frame high total", hsum, 10);
          chk(first_bad == 0, "R4 first pulse wide", first_bad, 0);
          chk(rdy_bad == 0, "R6 ready only at frame end", rdy_bad, 0);
          fs = -1;
        end
      end
      prev_valid = rx_valid;
      prev_line  = tx_line;
    end
  end

  task automatic idle_check();
    int hi;
    do @(negedge clk); while (tx_line);
    do @(negedge clk); while (!tx_line);
    hi = 1;
    repeat (3) begin
      @(negedge clk);
      hi += int'(tx_line);
    end
    chk(hi == 2, "R3 idle pulse width", hi, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog expired", cyc, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base;
    rst_n    = 1'b0;
    tx_valid = 1'b0;
    tx_data  = '0;
    inj_en   = 1'b0;
    inj_line = 1'b0;
    repeat (4) @(negedge clk);
    chk(tx_ready == 1'b1, "R1 tx_ready in reset", int'(tx_ready), 1);
    chk(tx_line == 1'b0, "R1 tx_line in reset", int'(tx_line), 0);
    chk(rx_valid == 1'b0, "R1 rx_valid in reset", int'(rx_valid), 0);
    chk(rx_err == 1'b0, "R1 rx_err in reset", int'(rx_err), 0);
    rst_n = 1'b1;

    repeat (40) @(negedge clk);
    idle_check();
    idle_check();
    chk(err_cnt == 0, "R3 no error in idle", err_cnt, 0);

    // every nibble back to back
    for (int n = 0; n < 16; n++) send(n);
    repeat (60) @(negedge clk);
    chk(q_data.size() == 0, "R7 all nibbles delivered", q_data.size(), 0);

    // gaps and varied order
    send(10);
    repeat (7) @(negedge clk);
    send(3);
    send(15);
    repeat (13) @(negedge clk);
    send(0);
    repeat (60) @(negedge clk);
    chk(q_data.size() == 0, "R6/R7 gapped nibbles delivered", q_data.size(), 0);
    idle_check();

    // injected line: narrow and normal pulses while hunting are ignored
    base = err_cnt;
    inj_en = 1'b1;
    inj_line = 1'b0;
    repeat (8) @(negedge clk);
    repeat (3) inj_pulse(1, 4);
    repeat (3) inj_pulse(2, 4);
    repeat (8) @(negedge clk);
    chk(err_cnt == base, "R8 narrow ignored while hunting", err_cnt, base);

    // wide then four normals: trits sum to 4, illegal
    inj_pulse(3, 4);
    repeat (4) inj_pulse(2, 4);
    repeat (6) inj_pulse(2, 4);
    chk(err_cnt == base + 1, "R9 unbalanced frame flagged", err_cnt, base + 1);

    // wide then trits 0,0,1,2 -> nibble 0
    q_data.push_back(0);
    q_due.push_back(-1);
    inj_pulse(3, 4);
    inj_pulse(1, 4);
    inj_pulse(1, 4);
    inj_pulse(2, 4);
    inj_pulse(3, 4);
    repeat (6) inj_pulse(2, 4);
    chk(q_data.size() == 0, "R8 injected frame decoded", q_data.size(), 0);
    chk(err_cnt == base + 1, "R9 no error on legal frame", err_cnt, base + 1);

    // over-long pulse inside a frame is invalid
    inj_pulse(3, 4);
    inj_pulse(4, 8);
    inj_pulse(1, 4);
    inj_pulse(2, 4);
    inj_pulse(1, 4);
    repeat (6) inj_pulse(2, 4);
    chk(err_cnt == base + 2, "R8/R9 over-long pulse flagged", err_cnt, base + 2);

    // back to the transmitter; receiver recovers
    inj_en = 1'b0;
    repeat (12) @(negedge clk);
    send(5);
    send(12);
    repeat (60) @(negedge clk);
    chk(q_data.size() == 0, "R9 recovery after error", q_data.size(), 0);
    chk(err_cnt == base + 2, "R9 no further errors", err_cnt, base + 2);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule